// File: doc/BRIEF.md
# Indirect-Window Host Register Interface

This block is a slave on an asynchronous, strobe-driven host bus. A 4-bit register address selects one of sixteen direct slots. The slots hold interrupt enable and flag registers, bus and memory width modes, two clock-configuration words and a reboot command. Three slots form a window into an internal word RAM: a stage word, an address word and a data port. Every access to the data port moves the internal byte pointer on by the width of the access, so a host can stream blocks of words without reloading the address.

The host drives chip select, a read or write strobe, the address and, for writes, the data. It holds all of them until the block pulls the active-low acknowledge down. Read data is valid while acknowledge is low. Strobes are synchronised inside the block. Address and data are sampled once the synchronised strobe is seen, which is safe because the host holds them stable. Width codes in the bus mode and memory mode registers choose between 16-bit and 32-bit host transfers and between 16-bit and 32-bit indirect steps.

Top module: `hreg_host_if`

## Requirements
- R1: After reset the registers read: interrupt enable (slot 0x5) 0x0000, interrupt flags (0x6) 0x000F, bus mode (0x8) 0x0005, memory mode (0x9) 0x0009, clock-high (0xE) 0x0008, clock-low (0xF) 0x0006. After reset, ack_n is high.
- R2: ack_n goes low only after cs_n is low together with rd_n or we_n. It stays low while they are held, and it returns high after they are released. One held strobe performs exactly one register side effect.
- R3: Slots 0x5, 0x8, 0x9, 0xE and 0xF store a 16-bit written value. While bus mode is not 0x000A, bits 31:16 of wdata are ignored and rdata[31:16] reads zero.
- R4: Writing slot 0x6 clears each flag whose wdata bit is 1 and leaves the others unchanged. A 1 on a flag_set bit sets that flag. irq_n is low exactly when some flag bit and its enable bit are both 1.
- R5: With memory mode not 0x000A, the pointer is formed with slot 0xA as bits 31:16 and slot 0xB as bits 15:0. Slot 0xB reads back pointer bits 15:0 and slot 0xA reads back bits 31:16.
- R6: With memory mode 0x000A, one write to slot 0xB loads the full 32-bit pointer, and slot 0xB reads the full pointer. With bus mode 0x000A, the host path is 32 bits wide.
- R7: Each read or write of slot 0xC advances the pointer by 2 in 16-bit indirect mode and by 4 in 32-bit indirect mode.
- R8: Half-words are big-endian. A 16-bit access at byte offset 0 of a word uses bits 31:16 and one at offset 2 uses bits 15:0. 16-bit reads return half-words in the order they were written.
- R9: The RAM covers DEPTH words from byte address WIN_BASE, 0x001B0000 by default. Outside that range, data-port reads return zero and writes change nothing.
- R10: Writing 0x008A to slot 0xD restores every direct register to its reset value. Any other value written there has no effect.
- R11: Slots 0x0 to 0x4, 0x7 and 0xD read zero, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| addr | input | 4 | Direct register slot |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, valid while ack_n is low |
| ack_n | output | 1 | Access acknowledge, active low |
| flag_set | input | 16 | Per-bit interrupt flag set requests |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The window is exercised with four patterns:
- Half-word writes that build words, read back by half-words after a pointer reload. This separates a correct big-endian order from a swapped one.
- The same words read as full words in 32-bit mode. This shows whether the two halves land in the right lanes.
- A switch back to 16-bit steps with the stage word kept. This shows whether the pointer halves stay independent.
- A pointer outside the window. This shows whether decoding looks only at the low bits, which would alias the write onto live data.

A strobe held for many cycles, followed by a pointer readback, tells one side effect per access apart from repeated ones. Flag writes with zero and with single bits set tell write-one-to-clear apart from plain writes.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;

  localparam logic [3:0] SLOT_IRQ_EN   = 4'h5;
  localparam logic [3:0] SLOT_IRQ_FLG  = 4'h6;
  localparam logic [3:0] SLOT_SW_FLG   = 4'h7;
  localparam logic [3:0] SLOT_BUS_MODE = 4'h8;
  localparam logic [3:0] SLOT_MEM_MODE = 4'h9;
  localparam logic [3:0] SLOT_STAGE    = 4'hA;
  localparam logic [3:0] SLOT_IADDR    = 4'hB;
  localparam logic [3:0] SLOT_IDATA    = 4'hC;
  localparam logic [3:0] SLOT_BOOT     = 4'hD;
  localparam logic [3:0] SLOT_CLK_HI   = 4'hE;
  localparam logic [3:0] SLOT_CLK_LO   = 4'hF;

  localparam logic [15:0] RST_IRQ_EN   = 16'h0000;
  localparam logic [15:0] RST_IRQ_FLG  = 16'h000F;
  localparam logic [15:0] RST_BUS_MODE = 16'h0005;
  localparam logic [15:0] RST_MEM_MODE = 16'h0009;
  localparam logic [15:0] RST_CLK_HI   = 16'h0008;
  localparam logic [15:0] RST_CLK_LO   = 16'h0006;

  localparam logic [15:0] WIDE_CODE = 16'h000A;
  localparam logic [15:0] BOOT_KEY  = 16'h008A;

endpackage

// File: rtl/hreg_handshake.sv
module hreg_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic we_n,
  output logic ack_n,
  output logic fire,
  output logic fire_wr
);
  import hreg_pkg::*;

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] cs_q, rd_q, we_q;
  logic         req_s, wr_s;
  hs_state_e    state_q, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      rd_q <= '0;
      we_q <= '0;
    end else begin
      cs_q <= {cs_q[TOP-1:0], ~cs_n};
      rd_q <= {rd_q[TOP-1:0], ~rd_n};
      we_q <= {we_q[TOP-1:0], ~we_n};
    end
  end

  assign req_s = cs_q[TOP] & (rd_q[TOP] | we_q[TOP]);
  assign wr_s  = we_q[TOP];

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      HS_IDLE: if (req_s) state_nx = HS_WAIT;
      HS_WAIT: state_nx = HS_DONE;
      HS_DONE: if (!req_s) state_nx = HS_IDLE;
      default: state_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_nx;
  end

  assign fire    = (state_q == HS_WAIT);
  assign fire_wr = fire & wr_s;
  assign ack_n   = (state_q != HS_DONE);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(req_s, 2)); // R2
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && req_s) |=> !ack_n); // R2
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R2

endmodule

// File: rtl/hreg_ptr.sv
module hreg_ptr #(
  parameter int AW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          ld_full,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          step_wide,
  output logic [AW-1:0] ptr
);
  localparam int NARROW_BYTES = HW / 8;
  localparam int WIDE_BYTES   = AW / 8;

  logic [AW-1:0] ptr_q, ptr_nx, inc;

  assign inc = step_wide ? AW'(WIDE_BYTES) : AW'(NARROW_BYTES);

  always_comb begin
    ptr_nx = ptr_q;
    if (clr)          ptr_nx = '0;
    else if (ld_full) ptr_nx = ld_val;
    else if (ld_hi)   ptr_nx[AW-1:AW-HW] = ld_val[HW-1:0];
    else if (ld_lo)   ptr_nx[HW-1:0] = ld_val[HW-1:0];
    else if (step)    ptr_nx = ptr_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nx;
  end

  assign ptr = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !ld_full && !ld_hi && !ld_lo) |=> ptr_q == $past(ptr_q) + $past(inc)); // R7

endmodule

// File: rtl/hreg_ind_ram.sv
module hreg_ind_ram #(
  parameter int              DEPTH    = 1024,
  parameter int              DW       = 32,
  parameter int              AW       = 32,
  parameter logic [AW-1:0]   WIN_BASE = 32'h001B_0000
) (
  input  logic          clk,
  input  logic [AW-1:0] byte_addr,
  input  logic          wr_en,
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int HALF  = DW / 2;
  localparam int LSB   = $clog2(DW / 8);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_L = IDX_W + LSB;

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             low_half;
  logic [1:0][HALF-1:0] lane_rd;

  assign in_win   = (byte_addr[AW-1:TAG_L] == WIN_BASE[AW-1:TAG_L]);
  assign idx      = byte_addr[TAG_L-1:LSB];
  assign low_half = byte_addr[LSB-1];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [HALF-1:0] mem [DEPTH];
    logic            hit, we;
    logic [HALF-1:0] wd;
    assign hit = (g == 1) ? !low_half : low_half;
    assign we  = wr_en & in_win & (wide | hit);
    assign wd  = wide ? wdata[g*HALF +: HALF] : wdata[HALF-1:0];
    always_ff @(posedge clk) begin
      if (we) mem[idx] <= wd;
    end
    assign lane_rd[g] = mem[idx];
  end

  always_comb begin
    if (!in_win)       rdata = '0;
    else if (wide)     rdata = {lane_rd[1], lane_rd[0]};
    else if (low_half) rdata = {{HALF{1'b0}}, lane_rd[0]};
    else               rdata = {{HALF{1'b0}}, lane_rd[1]};
  end

endmodule

// File: rtl/hreg_host_if.sv
module hreg_host_if #(
  parameter int          DEPTH       = 1024,
  parameter logic [31:0] WIN_BASE    = 32'h001B_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        we_n,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack_n,
  input  logic [15:0] flag_set,
  output logic        irq_n
);
  import hreg_pkg::*;

  localparam int DW = 32;
  localparam int HW = DW / 2;

  logic          fire, fire_wr, fire_rd;
  logic [HW-1:0] irq_en_q, irq_flg_q, bus_q, mem_q, clk_hi_q, clk_lo_q;
  logic [HW-1:0] irq_en_nx, irq_flg_nx, bus_nx, mem_nx, clk_hi_nx, clk_lo_nx;
  logic [DW-1:0] rdata_q, rd_mux, rd_eff, wd_eff, ptr, ram_rd;
  logic          host_wide, ind_wide, boot_hit, slot_wr_hit;
  logic [HW-1:0] wd16;

  hreg_handshake #(.SYNC_STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n),
    .ack_n(ack_n), .fire(fire), .fire_wr(fire_wr)
  );

  assign fire_rd   = fire & !fire_wr;
  assign host_wide = (bus_q == WIDE_CODE);
  assign ind_wide  = (mem_q == WIDE_CODE);
  assign wd16      = wdata[HW-1:0];
  assign wd_eff    = host_wide ? wdata : {{HW{1'b0}}, wd16};
  assign boot_hit  = fire_wr && (addr == SLOT_BOOT) && (wd16 == BOOT_KEY);
  assign slot_wr_hit = fire_wr && (addr == SLOT_IDATA);

  hreg_ptr #(.AW(DW), .HW(HW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(boot_hit),
    .ld_hi(fire_wr && addr == SLOT_STAGE),
    .ld_lo(fire_wr && addr == SLOT_IADDR && !ind_wide),
    .ld_full(fire_wr && addr == SLOT_IADDR && ind_wide),
    .ld_val(wd_eff),
    .step(fire && addr == SLOT_IDATA),
    .step_wide(ind_wide),
    .ptr(ptr)
  );

  hreg_ind_ram #(.DEPTH(DEPTH), .DW(DW), .AW(DW), .WIN_BASE(WIN_BASE)) u_ram (
    .clk(clk), .byte_addr(ptr), .wr_en(slot_wr_hit), .wide(ind_wide),
    .wdata(wd_eff), .rdata(ram_rd)
  );

  always_comb begin
    irq_en_nx  = irq_en_q;
    irq_flg_nx = irq_flg_q | flag_set;
    bus_nx     = bus_q;
    mem_nx     = mem_q;
    clk_hi_nx  = clk_hi_q;
    clk_lo_nx  = clk_lo_q;
    if (boot_hit) begin
      irq_en_nx  = RST_IRQ_EN;
      irq_flg_nx = RST_IRQ_FLG;
      bus_nx     = RST_BUS_MODE;
      mem_nx     = RST_MEM_MODE;
      clk_hi_nx  = RST_CLK_HI;
      clk_lo_nx  = RST_CLK_LO;
    end else if (fire_wr) begin
      unique case (addr)
        SLOT_IRQ_EN:   irq_en_nx  = wd16;
        SLOT_IRQ_FLG:  irq_flg_nx = (irq_flg_q & ~wd16) | flag_set;
        SLOT_BUS_MODE: bus_nx     = wd16;
        SLOT_MEM_MODE: mem_nx     = wd16;
        SLOT_CLK_HI:   clk_hi_nx  = wd16;
        SLOT_CLK_LO:   clk_lo_nx  = wd16;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      SLOT_IRQ_EN:   rd_mux = {{HW{1'b0}}, irq_en_q};
      SLOT_IRQ_FLG:  rd_mux = {{HW{1'b0}}, irq_flg_q};
      SLOT_BUS_MODE: rd_mux = {{HW{1'b0}}, bus_q};
      SLOT_MEM_MODE: rd_mux = {{HW{1'b0}}, mem_q};
      SLOT_STAGE:    rd_mux = {{HW{1'b0}}, ptr[DW-1:HW]};
      SLOT_IADDR:    rd_mux = ind_wide ? ptr : {{HW{1'b0}}, ptr[HW-1:0]};
      SLOT_IDATA:    rd_mux = ram_rd;
      SLOT_CLK_HI:   rd_mux = {{HW{1'b0}}, clk_hi_q};
      SLOT_CLK_LO:   rd_mux = {{HW{1'b0}}, clk_lo_q};
      default:       rd_mux = '0;
    endcase
    rd_eff = host_wide ? rd_mux : {{HW{1'b0}}, rd_mux[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= RST_IRQ_EN;
      irq_flg_q <= RST_IRQ_FLG;
      bus_q     <= RST_BUS_MODE;
      mem_q     <= RST_MEM_MODE;
      clk_hi_q  <= RST_CLK_HI;
      clk_lo_q  <= RST_CLK_LO;
      rdata_q   <= '0;
    end else begin
      irq_en_q  <= irq_en_nx;
      irq_flg_q <= irq_flg_nx;
      bus_q     <= bus_nx;
      mem_q     <= mem_nx;
      clk_hi_q  <= clk_hi_nx;
      clk_lo_q  <= clk_lo_nx;
      if (fire_rd) rdata_q <= rd_eff;
    end
  end

  assign rdata = rdata_q;
  assign irq_n = ~|(irq_flg_q & irq_en_q);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_wr && addr == SLOT_IRQ_FLG && flag_set == '0) |=> ((irq_flg_q & $past(wdata[HW-1:0])) == '0)); // R4
  AST_BOOT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    boot_hit |=> (bus_q == RST_BUS_MODE && mem_q == RST_MEM_MODE && irq_en_q == RST_IRQ_EN)); // R10
  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_rd && addr == SLOT_SW_FLG) |=> rdata == '0); // R11
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_rd && !host_wide) |=> rdata[DW-1:HW] == '0); // R3

endmodule

// File: tb/hreg_host_if_tb.sv
module hreg_host_if_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, we_n;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        ack_n;
  logic [15:0] flag_set;
  logic        irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  hreg_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n),
    .flag_set(flag_set), .irq_n(irq_n)
  );

  // Vector layout: {req[3:0], wr, slot[3:0], data[31:0], expected[31:0]}
  localparam int NV = 39;
  localparam logic [72:0] VEC [NV] = '{
    {4'd5,  1'b1, 4'hA, 32'h0000001B, 32'h0},          // R5 stage
    {4'd5,  1'b1, 4'hB, 32'h00000000, 32'h0},          // R5 low address
    {4'd8,  1'b1, 4'hC, 32'h00001234, 32'h0},          // R8 offset 0
    {4'd8,  1'b1, 4'hC, 32'h00005678, 32'h0},          // R8 offset 2
    {4'd8,  1'b1, 4'hC, 32'h00009ABC, 32'h0},
    {4'd8,  1'b1, 4'hC, 32'h0000DEF0, 32'h0},
    {4'd7,  1'b0, 4'hB, 32'h0,        32'h00000008},   // R7 four steps of 2
    {4'd5,  1'b0, 4'hA, 32'h0,        32'h0000001B},   // R5
    {4'd5,  1'b1, 4'hB, 32'h00000000, 32'h0},
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h00001234},   // R8 order kept
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h00005678},
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h00009ABC},
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h0000DEF0},
    {4'd7,  1'b0, 4'hB, 32'h0,        32'h00000008},   // R7 reads step too
    {4'd6,  1'b1, 4'h8, 32'h0000000A, 32'h0},          // R6 wide host
    {4'd6,  1'b1, 4'h9, 32'h0000000A, 32'h0},          // R6 wide indirect
    {4'd6,  1'b1, 4'hB, 32'h001B0000, 32'h0},          // R6 full pointer
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h12345678},   // R8 halves joined
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h9ABCDEF0},
    {4'd7,  1'b0, 4'hB, 32'h0,        32'h001B0008},   // R7 steps of 4
    {4'd6,  1'b1, 4'hC, 32'h0F0F0F0F, 32'h0},          // R6
    {4'd6,  1'b1, 4'hC, 32'hF0F0F0F0, 32'h0},
    {4'd5,  1'b0, 4'hA, 32'h0,        32'h0000001B},   // R5 stage readback
    {4'd5,  1'b1, 4'h9, 32'h00000009, 32'h0},          // R5 back to narrow
    {4'd5,  1'b1, 4'hB, 32'h00000008, 32'h0},          // R5 stage kept
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h00000F0F},   // R8
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h00000F0F},
    {4'd8,  1'b0, 4'hC, 32'h0,        32'h0000F0F0},
    {4'd7,  1'b0, 4'hB, 32'h0,        32'h0000000E},   // R7
    {4'd3,  1'b1, 4'h8, 32'h00000005, 32'h0},          // R3 narrow host
    {4'd3,  1'b1, 4'h5, 32'hABCD1234, 32'h0},          // R3 upper ignored
    {4'd3,  1'b0, 4'h5, 32'h0,        32'h00001234},   // R3
    {4'd3,  1'b1, 4'hE, 32'h00000010, 32'h0},
    {4'd3,  1'b0, 4'hE, 32'h0,        32'h00000010},   // R3
    {4'd11, 1'b1, 4'h7, 32'h0000FFFF, 32'h0},          // R11
    {4'd11, 1'b0, 4'h7, 32'h0,        32'h00000000},   // R11
    {4'd11, 1'b1, 4'h3, 32'h00000055, 32'h0},
    {4'd11, 1'b0, 4'h3, 32'h0,        32'h00000000},   // R11
    {4'd3,  1'b0, 4'h8, 32'h0,        32'h00000005}    // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(input logic level, input string tag);
    int i;
    for (i = 0; i < 40 && ack_n !== level; i++) @(negedge clk);
    if (ack_n !== level) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s: actual ack_n %b expected %b", tag, ack_n, level);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    addr  = a;
    wdata = d;
    cs_n  = 1'b0;
    if (wr) we_n = 1'b0; else rd_n = 1'b0;
    wait_ack(1'b0, "R2 ack assert");
    q = rdata;
    cs_n = 1'b1;
    rd_n = 1'b1;
    we_n = 1'b1;
    wait_ack(1'b1, "R2 ack release");
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] q;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; we_n = 1'b1;
    addr = '0; wdata = '0; flag_set = '0;
    repeat (5) @(negedge clk);
    check("R1 ack_n in reset", {31'b0, ack_n}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack_n idle", {31'b0, ack_n}, 32'd1);
    check("R4 irq_n idle", {31'b0, irq_n}, 32'd1);
    access(1'b0, 4'h5, 0, q); check("R1 slot 5", q, 32'h0000);
    access(1'b0, 4'h6, 0, q); check("R1 slot 6", q, 32'h000F);
    access(1'b0, 4'h8, 0, q); check("R1 slot 8", q, 32'h0005);
    access(1'b0, 4'h9, 0, q); check("R1 slot 9", q, 32'h0009);
    access(1'b0, 4'hE, 0, q); check("R1 slot E", q, 32'h0008);
    access(1'b0, 4'hF, 0, q); check("R1 slot F", q, 32'h0006);

    for (int v = 0; v < NV; v++) begin
      logic [72:0] e;
      e = VEC[v];
      access(e[68], e[67:64], e[63:32], q);
      if (!e[68]) check($sformatf("R%0d vector %0d", e[72:69], v), q, e[31:0]);
    end

    // R2: long-held strobe gives one side effect
    access(1'b1, 4'hB, 32'h0, q);
    @(negedge clk);
    addr = 4'hC; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R2 no early ack", {31'b0, ack_n}, 32'd1);
    wait_ack(1'b0, "R2 held ack");
    check("R2 held read data", rdata, 32'h1234);
    repeat (6) @(negedge clk);
    check("R2 ack stays low", {31'b0, ack_n}, 32'd0);
    cs_n = 1'b1; rd_n = 1'b1;
    wait_ack(1'b1, "R2 ack returns");
    access(1'b0, 4'hB, 0, q); check("R2 single step", q, 32'h0002);

    // R4: flags and interrupt
    access(1'b1, 4'h5, 32'h0, q);
    check("R4 masked irq", {31'b0, irq_n}, 32'd1);
    access(1'b1, 4'h5, 32'h0001, q);
    check("R4 enabled irq", {31'b0, irq_n}, 32'd0);
    access(1'b1, 4'h6, 32'h0000, q);
    access(1'b0, 4'h6, 0, q); check("R4 zero write keeps", q, 32'h000F);
    access(1'b1, 4'h6, 32'h0001, q);
    access(1'b0, 4'h6, 0, q); check("R4 one clears", q, 32'h000E);
    check("R4 irq released", {31'b0, irq_n}, 32'd1);
    access(1'b1, 4'h5, 32'h0400, q);
    @(negedge clk); flag_set = 16'h0400;
    @(negedge clk); flag_set = 16'h0000;
    check("R4 set raises irq", {31'b0, irq_n}, 32'd0);
    access(1'b0, 4'h6, 0, q); check("R4 set flag", q, 32'h040E);
    access(1'b1, 4'h6, 32'h0400, q);
    check("R4 clear drops irq", {31'b0, irq_n}, 32'd1);
    access(1'b0, 4'h6, 0, q); check("R4 others kept", q, 32'h000E);

    // R9: outside window
    access(1'b1, 4'hA, 32'h0020, q);
    access(1'b1, 4'hB, 32'h0000, q);
    access(1'b1, 4'hC, 32'hBEEF, q);
    access(1'b1, 4'hB, 32'h0000, q);
    access(1'b0, 4'hC, 0, q); check("R9 outside reads zero", q, 32'h0);
    access(1'b1, 4'hA, 32'h001B, q);
    access(1'b1, 4'hB, 32'h0000, q);
    access(1'b0, 4'hC, 0, q); check("R9 no alias write", q, 32'h1234);

    // R10: reboot command
    access(1'b1, 4'h9, 32'h000A, q);
    access(1'b1, 4'hE, 32'h0033, q);
    access(1'b1, 4'h5, 32'h0007, q);
    access(1'b1, 4'hD, 32'h0012, q);
    access(1'b0, 4'h9, 0, q); check("R10 wrong key ignored", q, 32'h000A);
    access(1'b0, 4'hD, 0, q); check("R11 boot slot reads zero", q, 32'h0);
    access(1'b1, 4'hD, 32'h008A, q);
    access(1'b0, 4'h5, 0, q); check("R10 enable restored", q, 32'h0000);
    access(1'b0, 4'h6, 0, q); check("R10 flags restored", q, 32'h000F);
    access(1'b0, 4'h8, 0, q); check("R10 bus mode restored", q, 32'h0005);
    access(1'b0, 4'h9, 0, q); check("R10 mem mode restored", q, 32'h0009);
    access(1'b0, 4'hE, 0, q); check("R10 clk hi restored", q, 32'h0008);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule